// File: doc/BRIEF.md
# Interleaved Streaming Convolution Layer

This block is one layer of a compact one-dimensional convolutional network for pulse tagging and energy estimation on sampled detector signals. Several channels share a single datapath: their samples arrive interleaved on one clock, one input vector per cycle. Each vector holds one value for every input feature map of the current channel. The block assigns each accepted vector to the next channel in round-robin order. For that channel it forms every output feature map as a weighted sum over a window of the most recent time steps of all input maps, adds a bias, and applies an activation that is fixed at elaboration.

Each channel keeps its own sample history, so one instance can serve a whole group of channels at the interleave factor the core clock allows. Because the history starts as zeros, a result is produced from the very first sample instead of after a full window. Weights, biases, kernel length, map counts, channel count and the fixed-point format are all parameters.

Top module: `conv1d_tdm`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0, `out_ch` is 0 and `out_data` is all zeros.
- R2: Every cycle with `in_valid` high produces exactly one cycle with `out_valid` high, two clock edges later. Back-to-back inputs give back-to-back outputs, with no stall.
- R3: Accepted vectors go to channels 0, 1, …, N_CH-1 and then back to 0. `out_ch` carries the channel of the result it accompanies.
- R4: Output map o is the bias of o plus the sum, over input maps i and taps k = 0…K-1, of weight[(o·N_IN+i)·K+k] times the sample of map i from k accepted vectors earlier on the same channel. Tap 0 is the current vector. Taps older than the first sample after reset count as zero. Data, weights and biases are signed 18-bit with 10 fractional bits. Input map i sits at bits [i·18 +: 18] and output map o at bits [o·18 +: 18].
- R5: A channel's result depends only on that channel's own earlier samples. Samples of the other channels do not affect it.
- R6: The wide sum plus bias is rounded to 10 fractional bits by adding half an LSB and shifting right arithmetically. It is then saturated to the range −131072…131071 before the activation.
- R7: With ReLU selected, negative saturated values become 0 and non-negative values pass unchanged.
- R8: With the sigmoid selected, the output is 1024 (1.0) for x ≥ 2048, 0 for x ≤ −2048, and otherwise (x >>> 2) + 512.
- R9: Cycles with `in_valid` low neither advance the channel sequence nor alter any history.
- R10: A kernel length of 6 follows the same rules as length 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector present this cycle |
| in_data | input | N_IN·W | One sample per input feature map |
| out_valid | output | 1 | Result present this cycle |
| out_ch | output | clog2(N_CH) | Channel of the result |
| out_data | output | N_OUT·W | One activated value per output feature map |

## Verification
Isolating one channel is the hardest thing to reach from the ports. Interleaving means a fault that mixes histories between channels only shows when neighbouring channels carry clearly different values, and only if bubbles in the stream land at awkward phases of the channel counter. The stimulus therefore gives each channel its own distinct ramp, inserts idle cycles at random points, and runs long saturating bursts of extreme values so that every history slot of every channel fills. A reference model, keyed by the bench's own channel count, is then compared against all three configurations.

// File: rtl/conv_pkg.sv
package conv_pkg;

   typedef enum logic [0:0] {
      ACT_RELU    = 1'b0,
      ACT_SIGMOID = 1'b1
   } act_e;

endpackage

// File: rtl/conv_history.sv
module conv_history #(
   parameter int N_CH = 6,
   parameter int N_IN = 2,
   parameter int K    = 3,
   parameter int W    = 18,
   parameter int CH_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [N_IN*W-1:0]     in_data,
   output logic [CH_W-1:0]       cur_ch,
   output logic [N_IN*K*W-1:0]   win
);

   localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

   logic [W-1:0] hist [N_CH][N_IN][K-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_ch <= '0;
         for (int c = 0; c < N_CH; c++)
            for (int i = 0; i < N_IN; i++)
               for (int k = 0; k < K-1; k++)
                  hist[c][i][k] <= '0;
      end else if (in_valid) begin
         for (int i = 0; i < N_IN; i++) begin
            hist[cur_ch][i][0] <= in_data[i*W +: W];
            for (int k = 1; k < K-1; k++)
               hist[cur_ch][i][k] <= hist[cur_ch][i][k-1];
         end
         cur_ch <= (cur_ch == LAST_CH) ? '0 : cur_ch + 1'b1;
      end
   end

   always_comb begin
      for (int i = 0; i < N_IN; i++) begin
         win[(i*K)*W +: W] = in_data[i*W +: W];
         for (int k = 1; k < K; k++)
            win[(i*K+k)*W +: W] = hist[cur_ch][i][k-1];
      end
   end

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cur_ch));

   // R3
   ch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cur_ch == LAST_CH) |=> cur_ch == '0);

endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
   parameter int NTAP  = 6,
   parameter int W     = 18,
   parameter int ACC_W = 40,
   parameter logic [NTAP*W-1:0] WVEC = '0
) (
   input  logic [NTAP*W-1:0]        win,
   output logic signed [ACC_W-1:0]  acc
);

   localparam int PW    = 2 * W;
   localparam int NPAIR = (NTAP + 1) / 2;

   logic signed [ACC_W-1:0] psum [NPAIR];

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic [W-1:0]          xa, wa;
      logic signed [PW-1:0]  pa;
      assign xa = win[(2*p)*W +: W];
      assign wa = WVEC[(2*p)*W +: W];
      assign pa = $signed({{W{xa[W-1]}}, xa}) * $signed({{W{wa[W-1]}}, wa});
      if (2*p + 1 < NTAP) begin : g_two
         logic [W-1:0]          xb, wb;
         logic signed [PW-1:0]  pb;
         assign xb = win[(2*p+1)*W +: W];
         assign wb = WVEC[(2*p+1)*W +: W];
         assign pb = $signed({{W{xb[W-1]}}, xb}) * $signed({{W{wb[W-1]}}, wb});
         assign psum[p] = $signed({{(ACC_W-PW){pa[PW-1]}}, pa})
                        + $signed({{(ACC_W-PW){pb[PW-1]}}, pb});
      end else begin : g_one
         assign psum[p] = $signed({{(ACC_W-PW){pa[PW-1]}}, pa});
      end
   end

   always_comb begin
      acc = '0;
      for (int p = 0; p < NPAIR; p++)
         acc = acc + psum[p];
   end

endmodule

// File: rtl/conv_act.sv
module conv_act
   import conv_pkg::*;
#(
   parameter int   W     = 18,
   parameter int   FRAC  = 10,
   parameter int   ACC_W = 40,
   parameter act_e ACT   = ACT_RELU,
   parameter logic [W-1:0] BIAS = '0
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [W-1:0]            y
);

   localparam int SW = ACC_W + 1;
   localparam logic signed [SW-1:0] HALF_LSB = SW'(1) <<< (FRAC - 1);
   localparam logic signed [SW-1:0] BIAS_X   =
      $signed({{(SW-W){BIAS[W-1]}}, BIAS}) <<< FRAC;

   logic signed [SW-1:0] summed, shifted;
   logic signed [W-1:0]  xsat;
   logic [SW-W:0]        hi;

   always_comb begin
      summed  = $signed({acc[ACC_W-1], acc}) + BIAS_X;
      shifted = (summed + HALF_LSB) >>> FRAC;
      hi      = shifted[SW-1:W-1];
      if ((&hi) || !(|hi))
         xsat = shifted[W-1:0];
      else if (shifted[SW-1])
         xsat = {1'b1, {(W-1){1'b0}}};
      else
         xsat = {1'b0, {(W-1){1'b1}}};
   end

   if (ACT == ACT_RELU) begin : g_relu
      assign y = xsat[W-1] ? '0 : xsat;
   end else begin : g_sigmoid
      localparam logic signed [W-1:0] ONE  = W'(1) <<< FRAC;
      localparam logic signed [W-1:0] TWO  = ONE <<< 1;
      localparam logic signed [W-1:0] NTWO = -TWO;
      localparam logic signed [W-1:0] HALF = ONE >>> 1;
      always_comb begin
         if (xsat >= TWO)
            y = ONE;
         else if (xsat <= NTWO)
            y = '0;
         else
            y = (xsat >>> 2) + HALF;
      end
   end

endmodule

// File: rtl/conv1d_tdm.sv
module conv1d_tdm
   import conv_pkg::*;
#(
   parameter int   N_CH  = 6,
   parameter int   N_IN  = 2,
   parameter int   N_OUT = 2,
   parameter int   K     = 3,
   parameter int   W     = 18,
   parameter int   FRAC  = 10,
   parameter act_e ACT   = ACT_RELU,
   parameter logic [N_OUT*N_IN*K*W-1:0] WEIGHTS = '0,
   parameter logic [N_OUT*W-1:0]        BIASES  = '0,
   localparam int  CH_W  = $clog2(N_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [N_IN*W-1:0]    in_data,
   output logic                 out_valid,
   output logic [CH_W-1:0]      out_ch,
   output logic [N_OUT*W-1:0]   out_data
);

   localparam int NTAP  = N_IN * K;
   localparam int ACC_W = 2 * W + $clog2(NTAP) + 1;

   if (N_CH < 2)        begin : g_bad_ch   $error("N_CH must be at least 2");        end
   if (K < 2)           begin : g_bad_k    $error("K must be at least 2");           end
   if (FRAC < 3)        begin : g_bad_frac $error("FRAC must be at least 3");        end
   if (W < FRAC + 3)    begin : g_bad_w    $error("W must exceed FRAC by 3 or more"); end

   logic [CH_W-1:0]          cur_ch;
   logic [NTAP*W-1:0]        win;
   logic signed [ACC_W-1:0]  acc_c [N_OUT];
   logic signed [ACC_W-1:0]  acc_q [N_OUT];
   logic [W-1:0]             act_y [N_OUT];
   logic                     v_q;
   logic [CH_W-1:0]          ch_q;

   conv_history #(
      .N_CH (N_CH), .N_IN (N_IN), .K (K), .W (W), .CH_W (CH_W)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .cur_ch   (cur_ch),
      .win      (win)
   );

   for (genvar o = 0; o < N_OUT; o++) begin : g_map
      conv_mac #(
         .NTAP (NTAP), .W (W), .ACC_W (ACC_W),
         .WVEC (WEIGHTS[o*NTAP*W +: NTAP*W])
      ) u_mac (
         .win (win),
         .acc (acc_c[o])
      );

      conv_act #(
         .W (W), .FRAC (FRAC), .ACC_W (ACC_W), .ACT (ACT),
         .BIAS (BIASES[o*W +: W])
      ) u_act (
         .acc (acc_q[o]),
         .y   (act_y[o])
      );

      // R7
      if (ACT == ACT_RELU) begin : g_chk_relu
         relu_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !out_data[o*W + W - 1]);
      end else begin : g_chk_sig
         // R8
         sig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($signed(out_data[o*W +: W]) >= 0 &&
                           $signed(out_data[o*W +: W]) <= (1 << FRAC)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q       <= 1'b0;
         ch_q      <= '0;
         out_valid <= 1'b0;
         out_ch    <= '0;
         out_data  <= '0;
         for (int o = 0; o < N_OUT; o++) acc_q[o] <= '0;
      end else begin
         v_q       <= in_valid;
         out_valid <= v_q;
         if (in_valid) begin
            ch_q <= cur_ch;
            for (int o = 0; o < N_OUT; o++) acc_q[o] <= acc_c[o];
         end
         if (v_q) begin
            out_ch <= ch_q;
            for (int o = 0; o < N_OUT; o++) out_data[o*W +: W] <= act_y[o];
         end
      end
   end

   // R2
   lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2)) |-> out_valid == $past(in_valid, 2));

   // R3
   ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_ch <= CH_W'(N_CH - 1));

endmodule

// File: tb/conv1d_tdm_test.sv
module conv1d_tdm_test;
   import conv_pkg::*;

   localparam int NCH  = 6;
   localparam int NI   = 2;
   localparam int NO   = 2;
   localparam int W    = 18;
   localparam int MAXB = NO * NI * 6 * W;

   function automatic logic [MAXB-1:0] mkw(int kk, int seed);
      logic [MAXB-1:0] v = '0;
      for (int j = 0; j < NO*NI*kk; j++) begin
         int t;
         if (j < NI*kk) t = (((j*7 + seed) % 13) + 1) * 60;
         else           t = (((j*37 + seed*11) % 41) - 20) * 53;
         v[j*W +: W] = W'(t);
      end
      return v;
   endfunction

   localparam logic [MAXB-1:0]   WA3 = mkw(3, 1);
   localparam logic [MAXB-1:0]   WA6 = mkw(6, 5);
   localparam logic [NO*W-1:0]   BV  = {W'(-300), W'(100)};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [NI*W-1:0] in_d = '0;
   int cyc = 0;

   logic ov_r, ov_s, ov_k;
   logic [2:0] och_r, och_s, och_k;
   logic [NO*W-1:0] od_r, od_s, od_k;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   conv1d_tdm #(.N_CH(NCH), .N_IN(NI), .N_OUT(NO), .K(3), .ACT(ACT_RELU),
      .WEIGHTS(WA3[NO*NI*3*W-1:0]), .BIASES(BV)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_d),
      .out_valid(ov_r), .out_ch(och_r), .out_data(od_r));

   conv1d_tdm #(.N_CH(NCH), .N_IN(NI), .N_OUT(NO), .K(3), .ACT(ACT_SIGMOID),
      .WEIGHTS(WA3[NO*NI*3*W-1:0]), .BIASES(BV)) uut_sig (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_d),
      .out_valid(ov_s), .out_ch(och_s), .out_data(od_s));

   conv1d_tdm #(.N_CH(NCH), .N_IN(NI), .N_OUT(NO), .K(6), .ACT(ACT_RELU),
      .WEIGHTS(WA6[NO*NI*6*W-1:0]), .BIASES(BV)) uut_k6 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_d),
      .out_valid(ov_k), .out_ch(och_k), .out_data(od_k));

   typedef struct packed {
      int due;
      int ch;
      logic [W-1:0] r0, r1, s0, s1, k0, k1;
   } exp_t;

   exp_t q[$];
   int sh [NCH][NI][6];
   int mch = 0;
   int tests = 0;
   int fails = 0;
   string tag = "R1";

   function automatic int model(int kk, logic [MAXB-1:0] wv, int o, int x0, int x1,
                                int c, bit sig);
      longint acc = 0;
      longint r;
      int b;
      for (int i = 0; i < NI; i++)
         for (int k = 0; k < kk; k++) begin
            int x, w;
            x = (k == 0) ? ((i == 0) ? x0 : x1) : sh[c][i][k-1];
            w = $signed(wv[((o*NI + i)*kk + k)*W +: W]);
            acc += longint'(x) * longint'(w);
         end
      b = $signed(BV[o*W +: W]);
      acc += longint'(b) * 1024;
      r = (acc + 512) >>> 10;
      if (r > 131071)  r = 131071;
      if (r < -131072) r = -131072;
      if (!sig) return (r < 0) ? 0 : int'(r);
      if (r >= 2048)  return 1024;
      if (r <= -2048) return 0;
      return int'(r >>> 2) + 512;
   endfunction

   task automatic check(string what, int got, int expv);
      tests++;
      if (got != expv) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, expv);
      end
   endtask

   task automatic push(int x0, int x1);
      exp_t e;
      in_valid = 1'b1;
      in_d = {W'(x1), W'(x0)};
      e.due = cyc + 2;
      e.ch  = mch;
      e.r0 = W'(model(3, WA3, 0, x0, x1, mch, 1'b0));
      e.r1 = W'(model(3, WA3, 1, x0, x1, mch, 1'b0));
      e.s0 = W'(model(3, WA3, 0, x0, x1, mch, 1'b1));
      e.s1 = W'(model(3, WA3, 1, x0, x1, mch, 1'b1));
      e.k0 = W'(model(6, WA6, 0, x0, x1, mch, 1'b0));
      e.k1 = W'(model(6, WA6, 1, x0, x1, mch, 1'b0));
      q.push_back(e);
      for (int i = 0; i < NI; i++) begin
         for (int k = 5; k > 0; k--) sh[mch][i][k] = sh[mch][i][k-1];
         sh[mch][i][0] = (i == 0) ? x0 : x1;
      end
      mch = (mch + 1) % NCH;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Output checker: R2 timing, R3 channel, R4/R7/R8/R10 values
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check("R2 valid relu", int'(ov_r), 1);
            check("R2 valid sig",  int'(ov_s), 1);
            check("R2 valid k6",   int'(ov_k), 1);
            check("R3 ch relu", int'(och_r), e.ch);
            check("R3 ch k6",   int'(och_k), e.ch);
            check("R7 relu map0", $signed(od_r[0 +: W]), $signed(e.r0));
            check("R7 relu map1", $signed(od_r[W +: W]), $signed(e.r1));
            check("R8 sig map0",  $signed(od_s[0 +: W]), $signed(e.s0));
            check("R8 sig map1",  $signed(od_s[W +: W]), $signed(e.s1));
            check("R10 k6 map0",  $signed(od_k[0 +: W]), $signed(e.k0));
            check("R10 k6 map1",  $signed(od_k[W +: W]), $signed(e.k1));
         end else begin
            check("R2 idle relu", int'(ov_r), 0);
            check("R2 idle k6",   int'(ov_k), 0);
         end
      end
   end

   initial begin
      while (cyc < 150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int dummy;
      dummy = int'($urandom(32'd20240611));
      for (int c = 0; c < NCH; c++)
         for (int i = 0; i < NI; i++)
            for (int k = 0; k < 6; k++) sh[c][i][k] = 0;
      repeat (3) @(negedge clk);
      tag = "R1";
      check("R1 valid", int'(ov_r | ov_s | ov_k), 0);
      check("R1 ch",    int'(och_r), 0);
      check("R1 data",  int'(|{od_r, od_s, od_k}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", int'(ov_r), 0);

      tag = "R4";
      push(1024, -512);
      idle(4);
      push(2048, 300);
      push(-700, 40);

      tag = "R9";
      idle(3);
      push(500, 500);
      idle(1);
      push(-500, 900);
      idle(7);
      push(100, -100);

      tag = "R5";
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < NCH; c++)
            push(c*900 - 2000 + r*37, 1500 - c*700 - r*11);

      tag = "R6";
      for (int n = 0; n < 4*NCH; n++) push(131071, 131071);
      for (int n = 0; n < 4*NCH; n++) push(-131072, -131072);
      for (int n = 0; n < 2*NCH; n++) push(131071, -131072);

      tag = "R4";
      for (int n = 0; n < 3000; n++) begin
         if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
         if (($urandom % 2) == 0)
            push(int'($urandom % 6001) - 3000, int'($urandom % 6001) - 3000);
         else
            push(int'($urandom % 262144) - 131072, int'($urandom % 262144) - 131072);
      end

      idle(6);
      check("R2 drained", q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule